// File: doc/BRIEF.md
# Bulk Endpoint DMA Slave with Transfer Termination

This block connects one bulk endpoint's two packet buffers to an external DMA controller that moves 16-bit words. The block raises `dma_dreq` when it can take or give a word. The controller answers each word with one pulse on `dma_dack`. That pulse is the only data strobe, because the block has no separate read or write strobes. The pulse is brought into the system clock domain and edge-detected, so one pulse moves exactly one word.

In the IN direction the DMA side fills a buffer. A buffer that reaches the maximum packet size is committed, and filling moves to the other buffer. The USB side pops the words of the committed buffer and frees it with `in_token`. In the OUT direction the USB side pushes received words into a buffer and closes the packet with `rx_end`. The DMA side then drains the committed packets in order.

A transfer stops for one of four reasons:
- the external end-of-transfer line rises;
- the programmed word count runs out, when counting is enabled;
- a short OUT packet has been fully drained, when short-packet stopping is enabled;
- software writes the enable bit to zero.

Each stop has its own effect on the buffers. A sticky status field records which causes have occurred.

Top module: `ep_dma_slave`

## Requirements
- R1: After reset `dma_dreq`, `stat_cause` and `tx_avail` are 0. When enabled in the IN direction (`cfg_dir`=1), `dma_dreq` is 1 while the buffer being filled is not committed.
- R2: Each `dma_dack` pulse that arrives while `dma_dreq` is high moves exactly one word. The IN words come out on `tx_data` in the order they were written.
- R3: An IN buffer that reaches MAXP_BYTES/2 words (32 by default) is committed, raises `tx_avail` with `tx_words`=32, and filling moves to the other buffer. When both buffers are committed, `dma_dreq` is 0.
- R4: A rising edge on `dma_eot` in the IN direction stops the transfer. It also commits the partly filled buffer, which is then offered with `tx_words` equal to its word count.
- R5: With `cfg_cnt_en`=1 the transfer stops after `cfg_count` words and commits the partial IN buffer. With `cfg_cnt_en`=0 the count has no effect.
- R6: In the OUT direction (`cfg_dir`=0), `dma_dreq` is 1 only while a received packet is committed. `dma_dout` presents that packet's words in receive order, and packets are drained oldest first.
- R7: With `cfg_short_en`=1 the transfer stops once a packet shorter than 32 words has been fully drained. With `cfg_short_en`=0 the block stays enabled and serves later packets.
- R8: A rising edge on `dma_eot` in the OUT direction stops the transfer and discards the rest of the packet being drained. The other buffer keeps its packet, and that packet is drained next after re-enable.
- R9: A configuration write with `cfg_en`=0 during a transfer stops it.
- R10: After any stop, `dma_dreq` falls within one clock and stays 0 until a configuration write with `cfg_en`=1. No word moves in that interval.
- R11: `stat_cause` is sticky and cleared by `stat_clr`. Bit 0 is the external end, bit 1 is count done, bit 2 is short packet, and bit 3 is disable.
- R12: A `dma_dack` pulse while `dma_dreq` is 0 moves no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | DMA enable value written |
| cfg_dir | input | 1 | 1 = IN (DMA fills), 0 = OUT (DMA drains); a change flushes both buffers |
| cfg_cnt_en | input | 1 | Stop when the word count runs out |
| cfg_short_en | input | 1 | Stop after a drained short OUT packet |
| cfg_count | input | CW | Transfer length in words |
| stat_clr | input | 1 | Clears the sticky cause bits |
| stat_cause | output | 4 | Sticky stop causes |
| dma_dreq | output | 1 | Request to the DMA controller |
| dma_dack | input | 1 | Acknowledge, used as the word strobe (asynchronous) |
| dma_eot | input | 1 | External end of transfer (asynchronous) |
| dma_din | input | DW | Word from the DMA controller (IN) |
| dma_dout | output | DW | Word to the DMA controller (OUT) |
| rx_push | input | 1 | USB side writes one received word |
| rx_data | input | DW | Received word |
| rx_end | input | 1 | End of received packet |
| tx_avail | output | 1 | A committed IN packet is waiting |
| tx_words | output | NW | Word count of the waiting IN packet |
| tx_data | output | DW | Current word of the waiting IN packet |
| tx_pop | input | 1 | Advance to the next IN word |
| in_token | input | 1 | IN token served; frees the waiting buffer |

## Verification
The failures to look for are wrong buffer state. A stale ready flag or a wrong per-buffer count shows up at the next USB pop or DMA read: a wrong `tx_words`, a word out of order on `tx_data` or `dma_dout`, or `dma_dreq` held high or low against the fill state. The bench reads these back word by word. A wrong stop cause shows in `stat_cause`, and a stop that fails to drop the request shows in `dma_dreq`, within the eight clocks of a strobe. A discarded or kept OUT buffer only becomes visible when the next packet is drained after re-enable, so the bench re-enables and checks that packet's first word.

// File: rtl/ep_dma_slave.sv
module ep_dma_slave #(
  parameter int DW = 16,
  parameter int MAXP_BYTES = 64,
  parameter int CW = 16,
  localparam int WPP = MAXP_BYTES / 2,
  localparam int AW = $clog2(WPP),
  localparam int NW = $clog2(WPP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_dir,
  input  logic          cfg_cnt_en,
  input  logic          cfg_short_en,
  input  logic [CW-1:0] cfg_count,
  input  logic          stat_clr,
  output logic [3:0]    stat_cause,
  output logic          dma_dreq,
  input  logic          dma_dack,
  input  logic          dma_eot,
  input  logic [DW-1:0] dma_din,
  output logic [DW-1:0] dma_dout,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_end,
  output logic          tx_avail,
  output logic [NW-1:0] tx_words,
  output logic [DW-1:0] tx_data,
  input  logic          tx_pop,
  input  logic          in_token
);

  logic [2:0] ack_s, eot_s;
  logic active, dir, cnt_en, short_en;
  logic [CW-1:0] rem;
  logic [DW-1:0] mem [2][WPP];
  logic [NW-1:0] cnt [2];
  logic [1:0] rdy, shrt;
  logic pb, cb;
  logic [AW-1:0] cp;

  logic dword, pw, cr, last, commit, release_b, flush, term;
  logic [NW-1:0] nc;
  logic [DW-1:0] wdat, rd_word;
  logic t_eot, t_cnt, t_shr, t_dis;
  logic [3:0] cause;

  assign dma_dreq  = active & (dir ? ~rdy[pb] : rdy[cb]);
  assign dword     = ack_s[1] & ~ack_s[2] & dma_dreq;
  assign pw        = dir ? dword : (rx_push & ~rdy[pb]);
  assign wdat      = dir ? dma_din : rx_data;
  assign nc        = cnt[pb] + NW'(pw);
  assign cr        = dir ? (tx_pop & rdy[cb]) : dword;
  assign last      = (NW'(cp) + NW'(1)) == cnt[cb];

  assign t_dis = cfg_wr & ~cfg_en & active;
  assign t_eot = eot_s[1] & ~eot_s[2] & active;
  assign t_cnt = dword & cnt_en & (rem == CW'(1));
  assign t_shr = ~dir & dword & last & shrt[cb] & short_en;
  assign cause = {t_dis, t_shr, t_cnt, t_eot};
  assign term  = |cause;

  assign commit = ~rdy[pb] & ((nc == NW'(WPP)) |
                  ((dir ? (t_eot | t_cnt) : rx_end) & (nc != '0)));
  assign release_b = dir ? (in_token & rdy[cb])
                         : ((dword & last) | (t_eot & rdy[cb]));
  assign flush = cfg_wr & cfg_en & (cfg_dir != dir);

  assign rd_word  = mem[cb][cp];
  assign dma_dout = rd_word;
  assign tx_data  = rd_word;
  assign tx_avail = dir & rdy[cb];
  assign tx_words = cnt[cb];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_s <= '0;
      eot_s <= '0;
    end else begin
      ack_s <= {ack_s[1:0], dma_dack};
      eot_s <= {eot_s[1:0], dma_eot};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; dir <= 1'b0; cnt_en <= 1'b0; short_en <= 1'b0;
      rem <= '0; stat_cause <= '0;
    end else begin
      stat_cause <= (stat_clr ? 4'b0 : stat_cause) | cause;
      if (cfg_wr) begin
        active <= cfg_en;
        if (cfg_en) begin
          dir <= cfg_dir; cnt_en <= cfg_cnt_en;
          short_en <= cfg_short_en; rem <= cfg_count;
        end
      end else begin
        active <= active & ~term;
        if (dword) rem <= rem - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rdy <= '0; shrt <= '0; pb <= 1'b0; cb <= 1'b0; cp <= '0;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (release_b && cb == 1'(i)) begin
          rdy[i] <= 1'b0;
          cnt[i] <= '0;
        end else if (pb == 1'(i) && !rdy[i]) begin
          cnt[i] <= nc;
          if (commit) begin
            rdy[i]  <= 1'b1;
            shrt[i] <= (nc != NW'(WPP));
          end
        end
      end
      if (commit) pb <= ~pb;
      if (release_b) begin
        cb <= ~cb;
        cp <= '0;
      end else if (cr) begin
        cp <= cp + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pw) mem[pb][cnt[pb][AW-1:0]] <= wdat;
  end

endmodule

module ep_dma_slave_chk #(
  parameter int NW = 6,
  parameter int WPP = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dreq,
  input logic          active,
  input logic          dir,
  input logic [1:0]    rdy,
  input logic [NW-1:0] cnt0,
  input logic [NW-1:0] cnt1,
  input logic [3:0]    stat,
  input logic          stat_clr,
  input logic          term,
  input logic          cfg_wr
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 <= NW'(WPP)) && (cnt1 <= NW'(WPP)));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && rdy == 2'b11) |-> !dreq);

  p_stop_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !cfg_wr) |=> !dreq);

  p_stay_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cfg_wr) |=> !dreq);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> ((stat & $past(stat)) == $past(stat)));

endmodule

bind ep_dma_slave ep_dma_slave_chk #(.NW(NW), .WPP(WPP)) chk_i (
  .clk(clk), .rst_n(rst_n), .dreq(dma_dreq), .active(active), .dir(dir),
  .rdy(rdy), .cnt0(cnt[0]), .cnt1(cnt[1]), .stat(stat_cause),
  .stat_clr(stat_clr), .term(term), .cfg_wr(cfg_wr)
);

// File: tb/ep_dma_slave_tb.sv
`timescale 1ns/1ps
module ep_dma_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cfg_dir = 0, cfg_cnt_en = 0, cfg_short_en = 0;
  logic [15:0] cfg_count = '0;
  logic stat_clr = 0;
  logic [3:0] stat_cause;
  logic dma_dreq, dma_dack = 0, dma_eot = 0;
  logic [15:0] dma_din = '0, dma_dout, rx_data = '0, tx_data;
  logic rx_push = 0, rx_end = 0, tx_avail, tx_pop = 0, in_token = 0;
  logic [5:0] tx_words;

  int checks = 0, failures = 0;
  logic [15:0] exp_w [0:127];

  always #2 clk = ~clk;

  ep_dma_slave dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic en, dir, ce, se, input logic [15:0] n);
    @(negedge clk);
    cfg_en = en; cfg_dir = dir; cfg_cnt_en = ce; cfg_short_en = se; cfg_count = n;
    cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
    @(negedge clk);
  endtask

  task automatic ack_word(input logic [15:0] d);
    @(negedge clk); dma_din = d; dma_dack = 1;
    repeat (4) @(negedge clk);
    dma_dack = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic eot_pulse();
    @(negedge clk); dma_eot = 1;
    repeat (4) @(negedge clk);
    dma_eot = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic push_rx(input logic [15:0] d);
    @(negedge clk); rx_data = d; rx_push = 1;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic end_rx();
    @(negedge clk); rx_end = 1;
    @(negedge clk); rx_end = 0;
  endtask

  task automatic pop_chk(input logic [15:0] e);
    @(negedge clk);
    check("R2 tx word order", tx_data, e);
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic token();
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0;
    @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic [15:0] e);
    @(negedge clk);
    check(req, dma_dout, e);
    ack_word(16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int n, m;
    void'($urandom(32'd6013));
    do_reset();
    check("R1 reset dreq", dma_dreq, 0);
    check("R1 reset stat", stat_cause, 0);
    check("R1 reset tx_avail", tx_avail, 0);

    // IN: partial second buffer closed by external end
    cfg(1, 1, 0, 0, 0);
    check("R1 dreq when enabled IN", dma_dreq, 1);
    n = 33 + int'($urandom % 30);
    for (int i = 0; i < n; i++) begin
      exp_w[i] = 16'($urandom);
      ack_word(exp_w[i]);
    end
    check("R3 first buffer committed", tx_avail, 1);
    check("R3 full packet words", tx_words, 32);
    check("R3 fill moved to other buffer", dma_dreq, 1);
    eot_pulse();
    check("R4 dreq low after eot", dma_dreq, 0);
    check("R11 eot cause bit0", stat_cause, 4'b0001);
    for (int i = 0; i < 32; i++) pop_chk(exp_w[i]);
    token();
    check("R4 partial buffer offered", tx_avail, 1);
    check("R4 partial word count", tx_words, n - 32);
    for (int i = 32; i < n; i++) pop_chk(exp_w[i]);
    token();
    check("R4 no more packets", tx_avail, 0);
    ack_word(16'hDEAD);
    check("R10 dreq stays low", dma_dreq, 0);
    cfg(1, 1, 0, 0, 0);
    ack_word(16'h1234);
    eot_pulse();
    check("R12 ignored strobe not stored", tx_words, 1);
    pop_chk(16'h1234);
    token();

    // IN: both buffers full
    do_reset();
    cfg(1, 1, 0, 0, 0);
    for (int i = 0; i < 64; i++) begin
      exp_w[i] = 16'($urandom);
      ack_word(exp_w[i]);
    end
    check("R3 both full stalls dreq", dma_dreq, 0);
    check("R3 no termination when full", stat_cause, 0);
    ack_word(16'hBEEF);
    for (int i = 0; i < 32; i++) pop_chk(exp_w[i]);
    token();
    check("R3 second full buffer", tx_words, 32);
    for (int i = 32; i < 64; i++) pop_chk(exp_w[i]);
    token();
    check("R12 stalled strobe dropped", tx_avail, 0);
    check("R1 dreq back after free", dma_dreq, 1);
    cfg(0, 1, 0, 0, 0);
    check("R9 disable stops dreq", dma_dreq, 0);
    check("R11 disable cause bit3", stat_cause, 4'b1000);
    @(negedge clk); stat_clr = 1;
    @(negedge clk); stat_clr = 0;
    check("R11 clear", stat_cause, 0);

    // count termination
    do_reset();
    cfg(1, 1, 1, 0, 5);
    for (int i = 0; i < 5; i++) begin
      exp_w[i] = 16'($urandom);
      ack_word(exp_w[i]);
    end
    check("R5 count stops dreq", dma_dreq, 0);
    check("R11 count cause bit1", stat_cause, 4'b0010);
    check("R5 partial committed", tx_avail, 1);
    check("R5 partial count", tx_words, 5);
    do_reset();
    cfg(1, 1, 0, 0, 5);
    for (int i = 0; i < 6; i++) ack_word(16'(i));
    check("R5 count ignored when disabled", dma_dreq, 1);
    check("R5 no cause", stat_cause, 0);

    // OUT with short packet stop
    do_reset();
    cfg(1, 0, 0, 1, 0);
    check("R6 no packet no dreq", dma_dreq, 0);
    m = 1 + int'($urandom % 31);
    for (int i = 0; i < 32 + m; i++) begin
      exp_w[i] = 16'($urandom);
      push_rx(exp_w[i]);
      if (i == 31) end_rx();
    end
    end_rx();
    check("R6 dreq with packet", dma_dreq, 1);
    for (int i = 0; i < 32 + m; i++) read_chk("R6 OUT word order", exp_w[i]);
    check("R7 short stops dreq", dma_dreq, 0);
    check("R11 short cause bit2", stat_cause, 4'b0100);

    do_reset();
    cfg(1, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) begin
      exp_w[i] = 16'($urandom);
      push_rx(exp_w[i]);
    end
    end_rx();
    for (int i = 0; i < 7; i++) read_chk("R6 OUT short word", exp_w[i]);
    check("R7 no stop without enable", stat_cause, 0);
    for (int i = 0; i < 3; i++) push_rx(16'hA0 + 16'(i));
    end_rx();
    check("R7 still enabled", dma_dreq, 1);
    read_chk("R7 later packet", 16'hA0);

    // OUT external end discards active buffer only
    do_reset();
    for (int i = 0; i < 37; i++) begin
      exp_w[i] = 16'($urandom);
      push_rx(exp_w[i]);
    end
    end_rx();
    cfg(1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) read_chk("R8 first packet word", exp_w[i]);
    eot_pulse();
    check("R8 dreq low after eot", dma_dreq, 0);
    check("R11 eot cause OUT", stat_cause, 4'b0001);
    ack_word(16'h0);
    cfg(1, 0, 0, 0, 0);
    check("R8 dreq for kept buffer", dma_dreq, 1);
    for (int i = 32; i < 37; i++) read_chk("R8 kept packet word", exp_w[i]);
    check("R8 drained", dma_dreq, 0);

    report();
  end
endmodule